// File: doc/BRIEF.md
# Subword Segment Repair Controller

This block allocates redundancy for an embedded RAM that has a few spare rows and a few spare column groups. Each memory word is split into equal subword lanes, and a spare column group covers one lane at one column address for all rows of one segment. Segments are formed by the upper row-address bits. After power-on reset the controller sits in a self-test phase. It accepts faulty-subword reports from an external test engine and decides at once, one report per cycle, whether each fault takes a spare column group or a spare row, or whether the RAM cannot be repaired.

Two fixed rules push faults toward spare rows. A row that already holds a faulty subword owned by a column group takes a spare row when it shows a second fault. A fault that lands in the same segment and column address as an earlier column-group fault on another row also takes a spare row. Any other fault takes the lowest free column group. When no column group is free it takes a spare row, and when neither is free it raises the fail flag.

When the test engine signals the end of the test, the controller enters normal mode. From then on it decodes every access address into redirect information. A hit on a spared row redirects the whole word. A hit on spared column groups redirects only the matching lanes.

Top module: `subword_repair_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `bist_run` is 1, and `repair_done`, `repair_fail`, `row_hit`, `row_sel`, `cg_hit` and `lane_mask` are all 0.
- R2: An uncovered fault that triggers no row rule takes the lowest-index free column group. That group is keyed by (segment = `flt_row[ROW_W-1 -: SEG_W]`, `flt_col`, `flt_sub`) and remembers the fault's row.
- R3: An uncovered fault whose row equals the remembered row of a valid column group takes the lowest-index free spare row.
- R4: An uncovered fault whose segment and column match a valid column group that remembers a different row takes the lowest-index free spare row.
- R5: When the preferred resource is exhausted, the fault falls back to the other kind. When both kinds are exhausted, `repair_fail` rises one cycle later and stays high.
- R6: A fault on a spared row, or one matching a valid group's (segment, column, lane) key, allocates nothing.
- R7: `bist_end` sampled high during the test phase makes `repair_done` 1 and `bist_run` 0 from the next cycle on. After that, fault reports change nothing.
- R8: In normal mode, an access whose row equals a spared row gives `row_hit`=1, `row_sel` = the lowest matching spare index, `lane_mask` all ones and `cg_hit` 0.
- R9: In normal mode, on an access without a row hit, `cg_hit[j]` is 1 for every valid group j whose segment and column match the access. `lane_mask` bit s (subword s, counted from the least significant lane) is 1 exactly when some such group holds lane s.
- R10: Before `repair_done`, all redirect outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, restarts the self-repair run |
| flt_valid | input | 1 | A faulty-subword report is present |
| flt_row | input | ROW_W | Row address of the fault |
| flt_col | input | COL_W | Column address of the fault |
| flt_sub | input | SUB_IW | Subword lane index of the fault |
| bist_end | input | 1 | Test engine has finished |
| acc_row | input | ROW_W | Normal-mode access row |
| acc_col | input | COL_W | Normal-mode access column |
| bist_run | output | 1 | Test phase active |
| repair_done | output | 1 | Allocation committed, normal mode |
| repair_fail | output | 1 | Some fault could not be covered |
| row_hit | output | 1 | Access row is replaced by a spare row |
| row_sel | output | RI_W | Index of the spare row used |
| cg_hit | output | N_SCG | Spare column groups serving the access |
| lane_mask | output | NSUB | Subword lanes steered to spare storage |

## Verification
Several properties are checked on every cycle. A full-row hit always masks every lane and no column group. Nothing redirects before completion. The done and fail flags are sticky and never coexist wrongly with the run flag. A covered fault leaves all repair registers unchanged, and a rise of the fail flag always follows an unplaceable report. Only the bench's scenarios can show that the allocation order itself is right: which fault lands in which spare under the two row rules, the fallbacks, and the exhaustion. The bench shows this by sweeping every access address after each run and comparing against its own allocation model.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {ACT_NONE, ACT_ROW, ACT_CG, ACT_FAIL} srr_act_e;
  typedef enum logic {ST_TEST, ST_DONE} srr_st_e;

  function automatic int idx_w(input int n);
    return ($clog2(n) > 0) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/srr_decide.sv
module srr_decide
  import srr_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 2,
  parameter int SUB_IW  = 2,
  parameter int SEG_W   = 1,
  parameter int N_SPROW = 4,
  parameter int N_SCG   = 2,
  parameter int RI_W    = 2,
  parameter int CI_W    = 1
) (
  input  logic [N_SPROW-1:0]             rv,
  input  logic [N_SPROW-1:0][ROW_W-1:0]  raddr,
  input  logic [N_SCG-1:0]               cv,
  input  logic [N_SCG-1:0][SEG_W-1:0]    cseg,
  input  logic [N_SCG-1:0][COL_W-1:0]    ccol,
  input  logic [N_SCG-1:0][SUB_IW-1:0]   csub,
  input  logic [N_SCG-1:0][ROW_W-1:0]    crow,
  input  logic [ROW_W-1:0]               f_row,
  input  logic [COL_W-1:0]               f_col,
  input  logic [SUB_IW-1:0]              f_sub,
  output srr_act_e                       act,
  output logic [RI_W-1:0]                row_idx,
  output logic [CI_W-1:0]                cg_idx,
  output logic                           covered,
  output logic                           rule_row,
  output logic                           rule_col
);
  logic [SEG_W-1:0] f_seg;
  logic row_free, cg_free;

  assign f_seg = f_row[ROW_W-1 -: SEG_W];

  always_comb begin
    covered  = 1'b0;
    rule_row = 1'b0;
    rule_col = 1'b0;
    row_free = 1'b0;
    cg_free  = 1'b0;
    row_idx  = '0;
    cg_idx   = '0;
    for (int i = 0; i < N_SPROW; i++)
      if (rv[i] && raddr[i] == f_row) covered = 1'b1;
    for (int j = 0; j < N_SCG; j++) begin
      if (cv[j]) begin
        if (cseg[j] == f_seg && ccol[j] == f_col && csub[j] == f_sub) covered = 1'b1;
        if (crow[j] == f_row) rule_row = 1'b1;
        if (cseg[j] == f_seg && ccol[j] == f_col && crow[j] != f_row) rule_col = 1'b1;
      end
    end
    for (int i = N_SPROW-1; i >= 0; i--)
      if (!rv[i]) begin row_free = 1'b1; row_idx = RI_W'(i); end
    for (int j = N_SCG-1; j >= 0; j--)
      if (!cv[j]) begin cg_free = 1'b1; cg_idx = CI_W'(j); end

    if (covered)                   act = ACT_NONE;
    else if (rule_row || rule_col) act = row_free ? ACT_ROW : (cg_free ? ACT_CG : ACT_FAIL);
    else                           act = cg_free ? ACT_CG : (row_free ? ACT_ROW : ACT_FAIL);
  end
endmodule

// File: rtl/srr_match.sv
module srr_match #(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 2,
  parameter int NSUB    = 4,
  parameter int SUB_IW  = 2,
  parameter int SEG_W   = 1,
  parameter int N_SPROW = 4,
  parameter int N_SCG   = 2,
  parameter int RI_W    = 2
) (
  input  logic                           en,
  input  logic [N_SPROW-1:0]             rv,
  input  logic [N_SPROW-1:0][ROW_W-1:0]  raddr,
  input  logic [N_SCG-1:0]               cv,
  input  logic [N_SCG-1:0][SEG_W-1:0]    cseg,
  input  logic [N_SCG-1:0][COL_W-1:0]    ccol,
  input  logic [N_SCG-1:0][SUB_IW-1:0]   csub,
  input  logic [ROW_W-1:0]               a_row,
  input  logic [COL_W-1:0]               a_col,
  output logic                           row_hit,
  output logic [RI_W-1:0]                row_sel,
  output logic [N_SCG-1:0]               cg_hit,
  output logic [NSUB-1:0]                lane_mask
);
  logic [SEG_W-1:0] a_seg;
  assign a_seg = a_row[ROW_W-1 -: SEG_W];

  always_comb begin
    row_hit   = 1'b0;
    row_sel   = '0;
    cg_hit    = '0;
    lane_mask = '0;
    for (int i = N_SPROW-1; i >= 0; i--)
      if (en && rv[i] && raddr[i] == a_row) begin row_hit = 1'b1; row_sel = RI_W'(i); end
    if (row_hit) lane_mask = '1;
    else
      for (int j = 0; j < N_SCG; j++)
        if (en && cv[j] && cseg[j] == a_seg && ccol[j] == a_col) begin
          cg_hit[j]          = 1'b1;
          lane_mask[csub[j]] = 1'b1;
        end
  end
endmodule

// File: rtl/subword_repair_ctrl.sv
module subword_repair_ctrl
  import srr_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 2,
  parameter int NSUB    = 4,
  parameter int SEG_W   = 1,
  parameter int N_SPROW = 4,
  parameter int N_SCG   = 2,
  localparam int SUB_IW = idx_w(NSUB),
  localparam int RI_W   = idx_w(N_SPROW),
  localparam int CI_W   = idx_w(N_SCG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [ROW_W-1:0]  flt_row,
  input  logic [COL_W-1:0]  flt_col,
  input  logic [SUB_IW-1:0] flt_sub,
  input  logic              bist_end,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [COL_W-1:0]  acc_col,
  output logic              bist_run,
  output logic              repair_done,
  output logic              repair_fail,
  output logic              row_hit,
  output logic [RI_W-1:0]   row_sel,
  output logic [N_SCG-1:0]  cg_hit,
  output logic [NSUB-1:0]   lane_mask
);
  srr_st_e state;
  logic [N_SPROW-1:0]            rv;
  logic [N_SPROW-1:0][ROW_W-1:0] raddr;
  logic [N_SCG-1:0]              cv;
  logic [N_SCG-1:0][SEG_W-1:0]   cseg;
  logic [N_SCG-1:0][COL_W-1:0]   ccol;
  logic [N_SCG-1:0][SUB_IW-1:0]  csub;
  logic [N_SCG-1:0][ROW_W-1:0]   crow;

  srr_act_e         act;
  logic [RI_W-1:0]  row_idx;
  logic [CI_W-1:0]  cg_idx;
  logic             covered, rule_row, rule_col;
  logic             take;   // a report is being applied this cycle

  assign bist_run    = (state == ST_TEST);
  assign repair_done = (state == ST_DONE);
  assign take        = bist_run && flt_valid;

  srr_decide #(.ROW_W(ROW_W), .COL_W(COL_W), .SUB_IW(SUB_IW), .SEG_W(SEG_W),
               .N_SPROW(N_SPROW), .N_SCG(N_SCG), .RI_W(RI_W), .CI_W(CI_W)) u_dec (
    .rv(rv), .raddr(raddr), .cv(cv), .cseg(cseg), .ccol(ccol), .csub(csub), .crow(crow),
    .f_row(flt_row), .f_col(flt_col), .f_sub(flt_sub),
    .act(act), .row_idx(row_idx), .cg_idx(cg_idx),
    .covered(covered), .rule_row(rule_row), .rule_col(rule_col));

  srr_match #(.ROW_W(ROW_W), .COL_W(COL_W), .NSUB(NSUB), .SUB_IW(SUB_IW), .SEG_W(SEG_W),
              .N_SPROW(N_SPROW), .N_SCG(N_SCG), .RI_W(RI_W)) u_match (
    .en(repair_done), .rv(rv), .raddr(raddr), .cv(cv), .cseg(cseg), .ccol(ccol), .csub(csub),
    .a_row(acc_row), .a_col(acc_col),
    .row_hit(row_hit), .row_sel(row_sel), .cg_hit(cg_hit), .lane_mask(lane_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_TEST;
      repair_fail <= 1'b0;
      rv <= '0; raddr <= '0;
      cv <= '0; cseg <= '0; ccol <= '0; csub <= '0; crow <= '0;
    end else begin
      if (bist_run && bist_end) state <= ST_DONE;
      if (take) begin
        case (act)
          ACT_ROW: begin
            rv[row_idx]    <= 1'b1;
            raddr[row_idx] <= flt_row;
          end
          ACT_CG: begin
            cv[cg_idx]   <= 1'b1;
            cseg[cg_idx] <= flt_row[ROW_W-1 -: SEG_W];
            ccol[cg_idx] <= flt_col;
            csub[cg_idx] <= flt_sub;
            crow[cg_idx] <= flt_row;
          end
          ACT_FAIL: repair_fail <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R6: a covered report leaves every repair register untouched
  a_r6_covered_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (take && covered) |=> ($stable(rv) && $stable(cv)));
  // R3/R4: a triggered row rule with a free spare row never consumes a column group
  a_r3_rule_takes_row: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !covered && (rule_row || rule_col) && !(&rv)) |=> $stable(cv));
  // R5: fail only follows an unplaceable report, and it sticks
  a_r5_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repair_fail) |-> $past(take && act == ACT_FAIL));
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    repair_fail |=> repair_fail);
  // R7: done is sticky and excludes the test phase
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    repair_done |=> (repair_done && !bist_run));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    repair_done |=> ($stable(rv) && $stable(cv) && $stable(raddr)));
  // R8: whole-word redirect on a spared row
  a_r8_row_full: assert property (@(posedge clk) disable iff (!rst_n)
    row_hit |-> (lane_mask == '1 && cg_hit == '0));
  // R10: quiet before completion
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !repair_done |-> (!row_hit && cg_hit == '0 && lane_mask == '0 && row_sel == '0));
endmodule

// File: tb/sim_subword_repair_ctrl.sv
module sim_subword_repair_ctrl;
  localparam int ROW_W = 3, COL_W = 2, NSUB = 4, SEG_W = 1, NR = 4, NC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_valid = 1'b0, bist_end = 1'b0;
  logic [ROW_W-1:0] flt_row = '0, acc_row = '0;
  logic [COL_W-1:0] flt_col = '0, acc_col = '0;
  logic [1:0] flt_sub = '0;
  logic bist_run, repair_done, repair_fail, row_hit;
  logic [1:0] row_sel;
  logic [NC-1:0] cg_hit;
  logic [NSUB-1:0] lane_mask;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  // bench allocation model
  bit       m_rv[NR];  int m_ra[NR];
  bit       m_cv[NC];  int m_cseg[NC], m_ccol[NC], m_csub[NC], m_crow[NC];
  bit       m_fail;

  subword_repair_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .NSUB(NSUB), .SEG_W(SEG_W),
                        .N_SPROW(NR), .N_SCG(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_row(flt_row), .flt_col(flt_col),
    .flt_sub(flt_sub), .bist_end(bist_end), .acc_row(acc_row), .acc_col(acc_col),
    .bist_run(bist_run), .repair_done(repair_done), .repair_fail(repair_fail),
    .row_hit(row_hit), .row_sel(row_sel), .cg_hit(cg_hit), .lane_mask(lane_mask));

  always #5 clk = ~clk;

  function automatic int seg_of(int r);
    return r >> (ROW_W - SEG_W);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    foreach (m_rv[i]) begin m_rv[i] = 0; m_ra[i] = 0; end
    foreach (m_cv[j]) begin m_cv[j] = 0; m_cseg[j] = 0; m_ccol[j] = 0; m_csub[j] = 0; m_crow[j] = 0; end
    m_fail = 0;
  endtask

  // apply one report following R2..R6
  task automatic model_fault(int r, int c, int s);
    bit hit = 0, want_row = 0;
    int fr = -1, fc = -1;
    foreach (m_rv[i]) if (m_rv[i] && m_ra[i] == r) hit = 1;
    foreach (m_cv[j]) if (m_cv[j]) begin
      if (m_cseg[j] == seg_of(r) && m_ccol[j] == c && m_csub[j] == s) hit = 1;
      if (m_crow[j] == r) want_row = 1;
      if (m_cseg[j] == seg_of(r) && m_ccol[j] == c) want_row = 1;
    end
    if (hit) return;
    for (int i = 0; i < NR; i++) if (!m_rv[i] && fr < 0) fr = i;
    for (int j = 0; j < NC; j++) if (!m_cv[j] && fc < 0) fc = j;
    if ((want_row && fr >= 0) || (!want_row && fc < 0 && fr >= 0)) begin
      m_rv[fr] = 1; m_ra[fr] = r;
    end else if (fc >= 0) begin
      m_cv[fc] = 1; m_cseg[fc] = seg_of(r); m_ccol[fc] = c; m_csub[fc] = s; m_crow[fc] = r;
    end else m_fail = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; flt_valid = 1'b0; bist_end = 1'b0;
    @(negedge clk);
    check("R1 run in reset", int'(bist_run), 1);
    check("R1 done in reset", int'(repair_done), 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check("R1 run", int'(bist_run), 1);
    check("R1 fail", int'(repair_fail), 0);
    check("R1 mask", int'(lane_mask), 0);
    check("R1 hit", int'(row_hit), 0);
  endtask

  task automatic send(int r, int c, int s, bit to_model);
    flt_valid = 1'b1; flt_row = r[ROW_W-1:0]; flt_col = c[COL_W-1:0]; flt_sub = s[1:0];
    @(negedge clk);
    flt_valid = 1'b0;
    if (to_model) model_fault(r, c, s);
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < (1 << ROW_W); r++)
      for (int c = 0; c < (1 << COL_W); c++) begin
        int e_hit = 0, e_sel = 0, e_cg = 0, e_mask = 0;
        acc_row = r[ROW_W-1:0]; acc_col = c[COL_W-1:0];
        #1;
        if (repair_done) begin
          for (int i = NR-1; i >= 0; i--) if (m_rv[i] && m_ra[i] == r) begin e_hit = 1; e_sel = i; end
          if (e_hit == 1) e_mask = (1 << NSUB) - 1;
          else
            for (int j = 0; j < NC; j++)
              if (m_cv[j] && m_cseg[j] == seg_of(r) && m_ccol[j] == c) begin
                e_cg |= (1 << j); e_mask |= (1 << m_csub[j]);
              end
        end
        check({tag, " R8 row_hit"}, int'(row_hit), e_hit);
        check({tag, " R8 row_sel"}, int'(row_sel), e_sel);
        check({tag, " R9 cg_hit"}, int'(cg_hit), e_cg);
        check({tag, " R9 lane_mask"}, int'(lane_mask), e_mask);
      end
  endtask

  task automatic finish_test(string tag);
    sweep({tag, " R10 pre-done"});
    bist_end = 1'b1;
    @(negedge clk);
    bist_end = 1'b0;
    check({tag, " R7 done"}, int'(repair_done), 1);
    check({tag, " R7 run"}, int'(bist_run), 0);
    check({tag, " R5 fail"}, int'(repair_fail), int'(m_fail));
    sweep(tag);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);

    // A: no faults
    do_reset();
    finish_test("A");

    // B: one isolated fault -> column group 0 (R2)
    do_reset();
    send(1, 2, 3, 1);
    finish_test("B R2");
    acc_row = 3'd0; acc_col = 2'd2; #1;
    check("R2 lane 3 redirected", int'(lane_mask), 8);
    acc_row = 3'd5; #1;
    check("R2 other segment untouched", int'(lane_mask), 0);

    // C: rule on same row (R3)
    do_reset();
    send(3, 1, 0, 1); send(3, 2, 1, 1);
    finish_test("C R3");
    acc_row = 3'd3; acc_col = 2'd0; #1;
    check("R3 spare row 0 used", int'(row_hit), 1);

    // D: rule on shared column in segment (R4)
    do_reset();
    send(1, 0, 2, 1); send(2, 0, 3, 1);
    finish_test("D R4");
    acc_row = 3'd2; acc_col = 2'd1; #1;
    check("R4 row 2 spared", int'(row_hit), 1);

    // E: covered reports, fallback, exhaustion (R5, R6)
    do_reset();
    send(0, 0, 0, 1); send(4, 1, 1, 1); send(1, 2, 2, 1);
    send(1, 3, 0, 1); send(2, 0, 0, 1);
    check("R6 covered no fail", int'(repair_fail), 0);
    send(5, 3, 3, 1); send(2, 1, 0, 1); send(6, 2, 1, 1);
    check("R5 no fail while space", int'(repair_fail), 0);
    send(3, 3, 2, 1);
    check("R5 fail on exhaustion", int'(repair_fail), 1);
    finish_test("E R5");

    // F: reports after done are ignored (R7)
    do_reset();
    send(6, 1, 2, 1);
    finish_test("F");
    send(6, 3, 0, 0); send(0, 0, 0, 0); send(7, 2, 1, 0);
    sweep("F R7 after done");
    check("R7 fail unchanged", int'(repair_fail), 0);

    // random runs
    for (int k = 0; k < 30; k++) begin
      int nf;
      do_reset();
      nf = 1 + int'($urandom_range(8));
      for (int f = 0; f < nf; f++)
        send(int'($urandom_range(7)), int'($urandom_range(3)), int'($urandom_range(3)), 1);
      finish_test("RND");
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule